// File: doc/BRIEF.md
# Merging Write-Back Buffer with Miss Snooping

This block sits between a write-back cache and the next memory level. It parks two kinds of line traffic on the way down: dirty lines evicted from the cache, and partial write data from a cache that does not allocate on a write miss. Each slot holds one line address, the line's bytes, and a per-byte valid mask. A write to a line that already owns a slot is folded into that slot instead of taking a new one.

Slots leave toward the next level oldest first. A slot is offered only when the next level reports no pending read. Once offered, the slot is held steady until the next level acknowledges it. Every cache miss probes the buffer with its line address. On a hit, the buffer returns the newest bytes it holds for that line in the same cycle, so the miss can be served without a read of the next level.

Top module: `merge_wb_buffer`

## Requirements
- R1: After reset the buffer is empty: `enq_ready` is 1, `drn_valid` is 0, and every snoop misses.
- R2: An enqueue to a line that holds no mergeable slot takes a new slot. Slots are offered on the drain port in arrival order. The drained line, data and mask are those of the oldest slot.
- R3: An enqueue to a line that already holds a mergeable slot takes no new slot. The bytes whose `enq_mask` bit is 1 overwrite that slot's bytes, and the slot's mask becomes the OR of the old mask and `enq_mask`.
- R4: `drn_valid` rises only in a cycle where `nxt_rd_busy` is 0. While `drn_valid` is 1 and `drn_ack` is 0, the offer is kept on the next cycle with the same line, data and mask, whatever `nxt_rd_busy` does.
- R5: While the oldest slot is being offered (`drn_valid` is 1), it is not merged into. An enqueue to its line takes a new slot.
- R6: A slot leaves the buffer at the clock edge where `drn_valid` and `drn_ack` are both 1. After that, a snoop to its line misses unless a newer slot holds the line.
- R7: `enq_ready` is 0 exactly when all slots are in use and no mergeable slot matches `enq_line`. An enqueue that is not ready changes nothing.
- R8: `snp_hit` is 1 in the same cycle as `snp_valid` whenever the probed line is held in the buffer, or is being accepted on the enqueue port in that cycle.
- R9: On a snoop hit, `snp_data` and `snp_mask` carry the union of every copy of the line, with newer bytes over older ones, and an enqueue accepted in the same cycle on top. Byte b is bits 8b+7..8b and maps to mask bit b. Bytes outside the mask read 0, on the drain port as well.
- R10: The buffer holds at most `N_ENT` (default 10) distinct slots of `LINE_BYTES` (default 64) bytes each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Enqueue can be accepted this cycle |
| enq_line | input | LINE_AW | Line address of the enqueue |
| enq_data | input | LINE_BYTES*8 | Line data; byte b at bits 8b+7..8b |
| enq_mask | input | LINE_BYTES | Byte valid mask of the enqueue |
| snp_valid | input | 1 | Miss lookup request |
| snp_line | input | LINE_AW | Line address being looked up |
| snp_hit | output | 1 | Lookup found the line (combinational) |
| snp_data | output | LINE_BYTES*8 | Merged bytes of the line on a hit |
| snp_mask | output | LINE_BYTES | Bytes present on a hit |
| nxt_rd_busy | input | 1 | Next level has a read pending |
| drn_valid | output | 1 | Oldest slot offered to the next level |
| drn_ack | input | 1 | Next level takes the offered slot |
| drn_line | output | LINE_AW | Line address of the offered slot |
| drn_data | output | LINE_BYTES*8 | Data of the offered slot |
| drn_mask | output | LINE_BYTES | Byte mask of the offered slot |

## Verification
The bench fills every slot while reads block the drain. It then checks that a new line stalls while a merge into a held line is still taken. A design that tested only occupancy would refuse the merge, and one that ignored occupancy would overwrite a slot. It enqueues to the head line while that line is offered. A design that merged there would change data already committed to the next level, and would break the hold check. It snoops a line that has both a draining copy and a newer copy, with a same-cycle write on top. Getting the overlay order wrong returns stale bytes. Random traffic over a small pool of lines mixes merges, stalls, read blocking and late acknowledges.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned WB_BYTE_W = 8;

  typedef enum logic {
    DRN_IDLE = 1'b0,
    DRN_HELD = 1'b1
  } drn_state_e;
endpackage

// File: rtl/wbuf_rst_sync.sv
module wbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/wbuf_cam.sv
module wbuf_cam #(
  parameter int unsigned N_ENT   = 10,
  parameter int unsigned LINE_AW = 26
) (
  input  logic [N_ENT-1:0]              slot_en,
  input  logic [N_ENT-1:0][LINE_AW-1:0] slot_line,
  input  logic [LINE_AW-1:0]            probe_line,
  output logic [N_ENT-1:0]              match
);
  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
    assign match[gi] = slot_en[gi] && (slot_line[gi] == probe_line);
  end
endmodule

// File: rtl/wbuf_pick.sv
module wbuf_pick #(
  parameter int unsigned N_ENT = 10,
  localparam int unsigned IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] req,
  output logic [IW-1:0]    idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/wbuf_overlay.sv
module wbuf_overlay #(
  parameter int unsigned N_ENT      = 10,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned DW        = LINE_BYTES * wbuf_pkg::WB_BYTE_W
) (
  input  logic [N_ENT-1:0]                 sel,
  input  logic [N_ENT-1:0][DW-1:0]         slot_data,
  input  logic [N_ENT-1:0][LINE_BYTES-1:0] slot_mask,
  input  logic                             top_sel,
  input  logic [DW-1:0]                    top_data,
  input  logic [LINE_BYTES-1:0]            top_mask,
  output logic [DW-1:0]                    out_data,
  output logic [LINE_BYTES-1:0]            out_mask
);
  localparam int unsigned BW = wbuf_pkg::WB_BYTE_W;

  always_comb begin
    out_data = '0;
    out_mask = '0;
    // slot 0 is the oldest, so later slots land on top
    for (int i = 0; i < N_ENT; i++) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (sel[i] && slot_mask[i][b]) begin
          out_data[b*BW +: BW] = slot_data[i][b*BW +: BW];
          out_mask[b]          = 1'b1;
        end
      end
    end
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (top_sel && top_mask[b]) begin
        out_data[b*BW +: BW] = top_data[b*BW +: BW];
        out_mask[b]          = 1'b1;
      end
    end
  end
endmodule

// File: rtl/merge_wb_buffer.sv
module merge_wb_buffer #(
  parameter int unsigned N_ENT      = 10,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned LINE_AW    = 26,
  localparam int unsigned DW        = LINE_BYTES * wbuf_pkg::WB_BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enq_valid,
  output logic                  enq_ready,
  input  logic [LINE_AW-1:0]    enq_line,
  input  logic [DW-1:0]         enq_data,
  input  logic [LINE_BYTES-1:0] enq_mask,
  input  logic                  snp_valid,
  input  logic [LINE_AW-1:0]    snp_line,
  output logic                  snp_hit,
  output logic [DW-1:0]         snp_data,
  output logic [LINE_BYTES-1:0] snp_mask,
  input  logic                  nxt_rd_busy,
  output logic                  drn_valid,
  input  logic                  drn_ack,
  output logic [LINE_AW-1:0]    drn_line,
  output logic [DW-1:0]         drn_data,
  output logic [LINE_BYTES-1:0] drn_mask
);
  import wbuf_pkg::*;

  localparam int unsigned CW = $clog2(N_ENT + 1);
  localparam int unsigned IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int unsigned BW = WB_BYTE_W;

  logic rst_ns;

  logic [N_ENT-1:0][LINE_AW-1:0]    line_q, line_n;
  logic [N_ENT-1:0][DW-1:0]         data_q, data_n;
  logic [N_ENT-1:0][LINE_BYTES-1:0] mask_q, mask_n;
  logic [CW-1:0]                    cnt_q, cnt_n;
  drn_state_e                       drn_st_q, drn_st_n;

  logic [N_ENT-1:0] slot_used;
  logic [N_ENT-1:0] slot_open;
  logic [N_ENT-1:0] enq_match;
  logic [N_ENT-1:0] snp_match;
  logic [N_ENT-1:0] snp_sel;
  logic [IW-1:0]    merge_idx;
  logic             merge_hit;
  logic             enq_fire;
  logic             pop;
  logic             store_en;
  logic             snp_from_enq;
  logic             snp_any;

  wbuf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  // occupancy map and the drain lock on the head slot
  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      slot_used[i] = (CW'(i) < cnt_q);
      slot_open[i] = slot_used[i];
    end
    if (drn_valid) slot_open[0] = 1'b0;
  end

  wbuf_cam #(.N_ENT(N_ENT), .LINE_AW(LINE_AW)) u_cam_enq (
    .slot_en    (slot_open),
    .slot_line  (line_q),
    .probe_line (enq_line),
    .match      (enq_match)
  );

  wbuf_pick #(.N_ENT(N_ENT)) u_pick_merge (
    .req (enq_match),
    .idx (merge_idx),
    .any (merge_hit)
  );

  wbuf_cam #(.N_ENT(N_ENT), .LINE_AW(LINE_AW)) u_cam_snp (
    .slot_en    (slot_used),
    .slot_line  (line_q),
    .probe_line (snp_line),
    .match      (snp_match)
  );

  // enqueue and drain handshakes
  assign enq_ready = merge_hit || (cnt_q < CW'(N_ENT));
  assign enq_fire  = enq_valid && enq_ready;
  assign drn_valid = (cnt_q != '0) && ((drn_st_q == DRN_HELD) || !nxt_rd_busy);
  assign pop       = drn_valid && drn_ack;
  assign store_en  = enq_fire || pop;

  assign drn_line = line_q[0];
  assign drn_data = data_q[0];
  assign drn_mask = mask_q[0];

  // snoop path, including an enqueue accepted in this cycle
  assign snp_sel      = snp_valid ? snp_match : '0;
  assign snp_from_enq = snp_valid && enq_fire && (enq_line == snp_line);
  assign snp_any      = |snp_sel;
  assign snp_hit      = snp_any || snp_from_enq;

  wbuf_overlay #(.N_ENT(N_ENT), .LINE_BYTES(LINE_BYTES)) u_overlay (
    .sel       (snp_sel),
    .slot_data (data_q),
    .slot_mask (mask_q),
    .top_sel   (snp_from_enq),
    .top_data  (enq_data),
    .top_mask  (enq_mask),
    .out_data  (snp_data),
    .out_mask  (snp_mask)
  );

  // next state of the slot array: merge or allocate, then shift on pop
  always_comb begin
    line_n = line_q;
    data_n = data_q;
    mask_n = mask_q;
    cnt_n  = cnt_q;
    if (enq_fire) begin
      if (merge_hit) begin
        for (int i = 0; i < N_ENT; i++) begin
          if (IW'(i) == merge_idx) begin
            for (int b = 0; b < LINE_BYTES; b++) begin
              if (enq_mask[b]) data_n[i][b*BW +: BW] = enq_data[b*BW +: BW];
            end
            mask_n[i] = mask_q[i] | enq_mask;
          end
        end
      end else begin
        for (int i = 0; i < N_ENT; i++) begin
          if (CW'(i) == cnt_q) begin
            line_n[i] = enq_line;
            mask_n[i] = enq_mask;
            for (int b = 0; b < LINE_BYTES; b++) begin
              data_n[i][b*BW +: BW] = enq_mask[b] ? enq_data[b*BW +: BW] : '0;
            end
          end
        end
        cnt_n = cnt_q + CW'(1);
      end
    end
    if (pop) begin
      for (int i = 0; i < N_ENT - 1; i++) begin
        line_n[i] = line_n[i+1];
        data_n[i] = data_n[i+1];
        mask_n[i] = mask_n[i+1];
      end
      mask_n[N_ENT-1] = '0;
      cnt_n = cnt_n - CW'(1);
    end
  end

  always_comb begin
    drn_st_n = (drn_valid && !drn_ack) ? DRN_HELD : DRN_IDLE;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q    <= '0;
      drn_st_q <= DRN_IDLE;
    end else begin
      if (store_en) cnt_q <= cnt_n;
      drn_st_q <= drn_st_n;
    end
  end

  // slot storage, no reset needed: slots above cnt_q are never read
  always_ff @(posedge clk) begin
    if (store_en) begin
      line_q <= line_n;
      data_q <= data_n;
      mask_q <= mask_n;
    end
  end
endmodule

// File: rtl/wbuf_merge_chk.sv
module wbuf_merge_chk #(
  parameter int unsigned N_ENT = 10,
  parameter int unsigned LINE_AW = 26,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned CW = $clog2(N_ENT + 1)
) (
  input logic                  clk,
  input logic                  rst_ns,
  input logic [CW-1:0]         occ,
  input logic                  enq_valid,
  input logic                  enq_ready,
  input logic                  snp_valid,
  input logic                  snp_hit,
  input logic                  nxt_rd_busy,
  input logic                  drn_valid,
  input logic                  drn_ack,
  input logic [LINE_AW-1:0]    drn_line,
  input logic [LINE_BYTES-1:0] drn_mask
);
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_ns)
    occ <= CW'(N_ENT)); // R10

  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_ns)
    (enq_valid && !enq_ready) |-> (occ == CW'(N_ENT))); // R7

  AST_DRAIN_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_ns)
    (drn_valid && !$past(drn_valid && !drn_ack)) |-> !nxt_rd_busy); // R4

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (drn_valid && !drn_ack) |=> (drn_valid && $stable(drn_line) && $stable(drn_mask))); // R4

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_ns)
    (drn_valid && drn_ack && !(enq_valid && enq_ready)) |=> (occ == $past(occ) - CW'(1))); // R6

  AST_EMPTY_SNOOP_MISS: assert property (@(posedge clk) disable iff (!rst_ns)
    (snp_valid && (occ == '0) && !enq_valid) |-> !snp_hit); // R8
endmodule

bind merge_wb_buffer wbuf_merge_chk #(
  .N_ENT(N_ENT), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)
) u_wbuf_merge_chk (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .occ         (cnt_q),
  .enq_valid   (enq_valid),
  .enq_ready   (enq_ready),
  .snp_valid   (snp_valid),
  .snp_hit     (snp_hit),
  .nxt_rd_busy (nxt_rd_busy),
  .drn_valid   (drn_valid),
  .drn_ack     (drn_ack),
  .drn_line    (drn_line),
  .drn_mask    (drn_mask)
);

// File: tb/test_merge_wb_buffer.sv
module test_merge_wb_buffer;
  localparam int NE = 10;
  localparam int LB = 64;
  localparam int AW = 26;
  localparam int DW = LB * 8;

  logic          clk;
  logic          rst_n;
  logic          enq_valid, enq_ready;
  logic [AW-1:0] enq_line;
  logic [DW-1:0] enq_data;
  logic [LB-1:0] enq_mask;
  logic          snp_valid, snp_hit;
  logic [AW-1:0] snp_line;
  logic [DW-1:0] snp_data;
  logic [LB-1:0] snp_mask;
  logic          nxt_rd_busy, drn_valid, drn_ack;
  logic [AW-1:0] drn_line;
  logic [DW-1:0] drn_data;
  logic [LB-1:0] drn_mask;

  int n_chk;
  int n_bad;

  merge_wb_buffer #(.N_ENT(NE), .LINE_BYTES(LB), .LINE_AW(AW)) i_merge_wb_buffer (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_line(enq_line),
    .enq_data(enq_data), .enq_mask(enq_mask),
    .snp_valid(snp_valid), .snp_line(snp_line), .snp_hit(snp_hit),
    .snp_data(snp_data), .snp_mask(snp_mask),
    .nxt_rd_busy(nxt_rd_busy), .drn_valid(drn_valid), .drn_ack(drn_ack),
    .drn_line(drn_line), .drn_data(drn_data), .drn_mask(drn_mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference state
  logic [AW-1:0] m_line [NE];
  logic [DW-1:0] m_data [NE];
  logic [LB-1:0] m_mask [NE];
  int            m_cnt;
  bit            m_held;

  function automatic logic [DW-1:0] expand(input logic [LB-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < LB; b++) r[b*8 +: 8] = m[b] ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd_line_data();
    logic [DW-1:0] r;
    for (int k = 0; k < DW / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic bit exp_offer(input bit busy);
    return (m_cnt > 0) && (m_held || !busy);
  endfunction

  function automatic int exp_merge_slot(input logic [AW-1:0] ln, input bit offer);
    for (int i = 0; i < m_cnt; i++) begin
      if (m_line[i] == ln && !(i == 0 && offer)) return i;
    end
    return -1;
  endfunction

  function automatic bit exp_ready(input logic [AW-1:0] ln, input bit offer);
    return (m_cnt < NE) || (exp_merge_slot(ln, offer) >= 0);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag, input bit ev, input logic [AW-1:0] ln,
                       input logic [DW-1:0] d, input logic [LB-1:0] m,
                       input bit sv, input logic [AW-1:0] sl,
                       input bit busy, input bit ack);
    bit offer, rdy, fire, pop, shit;
    int mi;
    logic [DW-1:0] sd;
    logic [LB-1:0] sm;
    @(negedge clk);
    enq_valid = ev; enq_line = ln; enq_data = d; enq_mask = m;
    snp_valid = sv; snp_line = sl; nxt_rd_busy = busy; drn_ack = ack;
    #1;
    offer = exp_offer(busy);
    rdy   = exp_ready(ln, offer);
    fire  = ev && rdy;
    pop   = offer && ack;
    mi    = exp_merge_slot(ln, offer);
    shit = 1'b0; sd = '0; sm = '0;
    if (sv) begin
      for (int i = 0; i < m_cnt; i++) begin
        if (m_line[i] == sl) begin
          shit = 1'b1;
          sd = (sd & ~expand(m_mask[i])) | (m_data[i] & expand(m_mask[i]));
          sm = sm | m_mask[i];
        end
      end
      if (fire && ln == sl) begin
        shit = 1'b1;
        sd = (sd & ~expand(m)) | (d & expand(m));
        sm = sm | m;
      end
    end
    chk(tag, "enq_ready", DW'(enq_ready), DW'(rdy));
    chk(tag, "drn_valid", DW'(drn_valid), DW'(offer));
    if (offer) begin
      chk(tag, "drn_line", DW'(drn_line), DW'(m_line[0]));
      chk(tag, "drn_data", drn_data, m_data[0]);
      chk(tag, "drn_mask", DW'(drn_mask), DW'(m_mask[0]));
    end
    chk(tag, "snp_hit", DW'(snp_hit), DW'(shit));
    if (shit) begin
      chk(tag, "snp_data", snp_data, sd);
      chk(tag, "snp_mask", DW'(snp_mask), DW'(sm));
    end
    @(posedge clk);
    if (fire) begin
      if (mi >= 0) begin
        m_data[mi] = (m_data[mi] & ~expand(m)) | (d & expand(m));
        m_mask[mi] = m_mask[mi] | m;
      end else begin
        m_line[m_cnt] = ln;
        m_data[m_cnt] = d & expand(m);
        m_mask[m_cnt] = m;
        m_cnt++;
      end
    end
    if (pop) begin
      for (int i = 0; i < NE - 1; i++) begin
        m_line[i] = m_line[i+1];
        m_data[i] = m_data[i+1];
        m_mask[i] = m_mask[i+1];
      end
      m_cnt--;
    end
    m_held = offer && !ack;
  endtask

  task automatic idle(input string tag, input bit busy);
    cycle(tag, 1'b0, '0, '0, '0, 1'b0, '0, busy, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    n_chk = 0; n_bad = 0; m_cnt = 0; m_held = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    enq_valid = 0; enq_line = '0; enq_data = '0; enq_mask = '0;
    snp_valid = 1; snp_line = 26'h5; nxt_rd_busy = 0; drn_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "enq_ready", DW'(enq_ready), DW'(1));
    chk("R1", "drn_valid", DW'(drn_valid), DW'(0));
    chk("R1", "snp_hit", DW'(snp_hit), DW'(0));
    rst_n = 1'b1;
    repeat (3) idle("R1", 1'b0);

    // R2/R10: fill all slots while reads block the drain
    for (int k = 0; k < NE; k++) begin
      d = rnd_line_data();
      cycle("R2", 1'b1, AW'(100 + k), d, {LB{1'b1}}, 1'b0, '0, 1'b1, 1'b0);
    end
    // R7: full, a new line stalls
    cycle("R7", 1'b1, AW'(200), rnd_line_data(), {LB{1'b1}}, 1'b1, AW'(200), 1'b1, 1'b0);
    // R3: merge into a held line is accepted while full
    cycle("R3", 1'b1, AW'(103), rnd_line_data(), 64'h0000_0000_FFFF_0000, 1'b1, AW'(103), 1'b1, 1'b0);
    // R9: snoop with same-cycle merge on top
    cycle("R9", 1'b1, AW'(103), rnd_line_data(), 64'h00FF_0000_0000_00F0, 1'b1, AW'(103), 1'b1, 1'b0);
    cycle("R9", 1'b0, '0, '0, '0, 1'b1, AW'(103), 1'b1, 1'b0);
    // R4: drain offered once reads stop, then held even if busy returns
    cycle("R4", 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
    cycle("R4", 1'b0, '0, '0, '0, 1'b0, '0, 1'b1, 1'b0);
    // R5: write to the offered head line with a slot free? full: stalls
    cycle("R5", 1'b1, AW'(100), rnd_line_data(), 64'hF, 1'b1, AW'(100), 1'b1, 1'b0);
    // R6: acknowledge, head leaves
    cycle("R6", 1'b0, '0, '0, '0, 1'b0, '0, 1'b1, 1'b1);
    cycle("R6", 1'b0, '0, '0, '0, 1'b1, AW'(100), 1'b1, 1'b0);
    // R5: head now 101 offered; write to 101 takes a new slot
    cycle("R5", 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
    cycle("R5", 1'b1, AW'(101), rnd_line_data(), 64'hFF00, 1'b1, AW'(101), 1'b1, 1'b0);
    // R9: both copies of 101 visible, newer on top
    cycle("R9", 1'b1, AW'(101), rnd_line_data(), 64'h0F0F, 1'b1, AW'(101), 1'b1, 1'b0);
    cycle("R6", 1'b0, '0, '0, '0, 1'b1, AW'(101), 1'b1, 1'b1);
    cycle("R6", 1'b0, '0, '0, '0, 1'b1, AW'(101), 1'b1, 1'b0);
    // R2: drain everything in order
    for (int k = 0; k < 3 * NE; k++) cycle("R2", 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, 1'b1);
    // R8: empty buffer, snoop misses
    cycle("R8", 1'b0, '0, '0, '0, 1'b1, AW'(104), 1'b0, 1'b0);

    // random traffic
    for (int k = 0; k < 6000; k++) begin
      logic [LB-1:0] m;
      m = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) m = m & {$urandom, $urandom} & {$urandom, $urandom};
      cycle((k % 2) ? "R3" : "R9",
            $urandom_range(0, 9) < 7, AW'($urandom_range(0, 11)), rnd_line_data(), m,
            $urandom_range(0, 1) == 1, AW'($urandom_range(0, 12)),
            $urandom_range(0, 9) < 6, $urandom_range(0, 9) < 3);
    end
    finish_run();
  end
endmodule